// File: doc/BRIEF.md
# PHY Reset and Strap Controller

This block orders the two kinds of reset seen by a single Ethernet PHY port. An active-low hardware reset input is brought into the clock domain with a synchronizer that asserts at once and releases on a clock edge. While that reset is held, the block keeps sampling the configuration strap pins. On the edge where the synchronized reset releases, it keeps the last sample in a shadow register. One cycle later it loads the strap-selected fields of the control register, releases the datapath and buffer resets, and lets the shared strap pins be driven as outputs.

A management port gives access to a small register set. Writing a 1 to bit 15 of register 0 starts a software reset. This holds only the datapath reset for a fixed number of cycles, and bit 15 reads back 1 for that whole time. A software reset leaves the strap shadow, the programmed register values and the buffer memory untouched. Only a new hardware reset samples the pins again and restores defaults.

Top module: `phy_rst_strap_ctrl`

## Requirements
- R1: While hw_rst_n is low, dp_rst_o and buf_rst_o are 1 and strap_oe_o is 0, with no clock edge needed. After hw_rst_n rises, all three keep these values through the second rising clock edge and change on the third.
- R2: The strap shadow takes the strap_i value present at the second rising edge after hw_rst_n rises. Register 1 reads that value zero-extended. Later changes on strap_i are not reflected.
- R3: After a hardware reset, register 0 bit 13 equals strap bit 0, bit 12 equals strap bit 1, bit 8 equals strap bit 2, and every other bit is 0. Register 2 reads 16'h00A5.
- R4: With hardware reset complete, a write stores bits 14:0 of register 0 and all of register 2. Register 1 is read-only. Addresses other than 0, 1 and 2 read as 0.
- R5: A register 0 write with bit 15 set holds dp_rst_o at 1 for exactly 16 cycles, starting in the cycle after the write edge. Bits 14:0 of the same write are stored. Register 0 bit 15 reads 1 while the software reset runs and 0 afterwards.
- R6: A software reset changes neither the strap shadow nor the stored values of registers 0 and 2, and it does not sample strap_i.
- R7: During a software reset, buf_rst_o stays 0 and strap_oe_o stays 1.
- R8: A register 0 write with bit 15 set that arrives while a software reset runs does not restart or lengthen it.
- R9: A hardware reset during a software reset ends it. After release, register 0 bit 15 reads 0 and the defaults and straps are loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| hw_rst_n | input | 1 | Asynchronous active-low hardware reset |
| strap_i | input | STRAP_W | Configuration strap pin levels |
| mgmt_we | input | 1 | Management register write strobe |
| mgmt_addr | input | 5 | Management register address |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_rdata | output | 16 | Management read data for mgmt_addr, combinational |
| dp_rst_o | output | 1 | Datapath reset, active high |
| buf_rst_o | output | 1 | Buffer memory reset, active high, hardware reset only |
| strap_oe_o | output | 1 | Shared strap pins may be driven as outputs |

## Verification
The bench changes the strap pins right after the capture edge and again in the middle of a software reset. A design that samples too late, or samples again on software reset, would show the newer pins in register 1 and register 0. It counts the software reset cycle by cycle. It sends a second reset write in mid-run, which a design that restarts its counter would answer by holding dp_rst_o too long. It also checks that programmed values survive the software reset, which a design that reloads defaults would lose. Finally it drops the hardware reset in the middle of a software reset: a design that leaves the sequencer running, or keeps the old straps, would show a stuck bit 15 or stale fields.

// File: rtl/phy_rst_pkg.sv
package phy_rst_pkg;
  localparam int REG_AW = 5;
  localparam int REG_DW = 16;

  localparam logic [REG_AW-1:0] ADDR_CTRL  = 5'd0;
  localparam logic [REG_AW-1:0] ADDR_STRAP = 5'd1;
  localparam logic [REG_AW-1:0] ADDR_CFG   = 5'd2;

  localparam int BIT_SWRST  = 15;
  localparam int BIT_SPEED  = 13;
  localparam int BIT_ANEG   = 12;
  localparam int BIT_DUPLEX = 8;

  // Overlay the strap-selected fields on a control value (bits 14:0).
  function automatic logic [REG_DW-2:0] ctrl_with_straps(
      input logic [REG_DW-2:0] cur, input logic [2:0] s);
    logic [REG_DW-2:0] v;
    v = cur;
    v[BIT_SPEED]  = s[0];
    v[BIT_ANEG]   = s[1];
    v[BIT_DUPLEX] = s[2];
    return v;
  endfunction

  // Last count value of a software reset window of len cycles.
  function automatic int unsigned swrst_last(input int unsigned len);
    return len - 1;
  endfunction
endpackage

// File: rtl/phy_rst_sync.sv
module phy_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= 1'b1;
        else chain_q[i] <= chain_q[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  assign rst_n_o = chain_q[STAGES-1];

  // R1
  sync_assert_chk: assert property (@(posedge clk) !arst_n |-> !rst_n_o);
endmodule

// File: rtl/phy_strap_latch.sv
module phy_strap_latch #(
  parameter int STRAP_W = 5
) (
  input  logic               clk,
  input  logic               rst_sync_n,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [STRAP_W-1:0] strap_q,
  output logic               strap_apply,
  output logic               hw_done
);
  // Follows the pins while held; the edge that releases reset keeps the last sample.
  always_ff @(posedge clk) begin
    if (!rst_sync_n) strap_q <= strap_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) hw_done <= 1'b0;
    else hw_done <= 1'b1;
  end

  assign strap_apply = rst_sync_n && !hw_done;

  // R2
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hw_done |=> $stable(strap_q));
endmodule

// File: rtl/phy_swrst_seq.sv
module phy_swrst_seq #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  output logic active_o
);
  localparam int CNT_W = (LEN > 2) ? $clog2(LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(phy_rst_pkg::swrst_last(LEN));

  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_o) begin
      if (start_req) begin
        active_o <= 1'b1;
        cnt_q    <= '0;
      end
    end else if (at_end) begin
      active_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5
  swrst_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_o && !at_end |=> active_o);
  // R5
  swrst_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_o && at_end |=> !active_o);
  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_o && start_req && !at_end |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs #(
  parameter int          STRAP_W     = 5,
  parameter logic [15:0] CFG_DEFAULT = 16'h00A5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hw_done,
  input  logic               strap_apply,
  input  logic [STRAP_W-1:0] strap_q,
  input  logic               we,
  input  logic [4:0]         addr,
  input  logic [15:0]        wdata,
  input  logic               swrst_active,
  output logic               swrst_req,
  output logic [15:0]        rdata
);
  import phy_rst_pkg::*;

  logic [REG_DW-2:0] ctrl_q;
  logic [REG_DW-1:0] cfg_q;
  logic              wr_ctrl, wr_cfg;

  assign wr_ctrl   = hw_done && we && (addr == ADDR_CTRL);
  assign wr_cfg    = hw_done && we && (addr == ADDR_CFG);
  assign swrst_req = wr_ctrl && wdata[BIT_SWRST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cfg_q  <= CFG_DEFAULT;
    end else begin
      if (strap_apply) ctrl_q <= ctrl_with_straps(ctrl_q, strap_q[2:0]);
      else if (wr_ctrl) ctrl_q <= wdata[REG_DW-2:0];
      if (wr_cfg) cfg_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_CTRL:  rdata = {swrst_active, ctrl_q};
      ADDR_STRAP: rdata = REG_DW'(strap_q);
      ADDR_CFG:   rdata = cfg_q;
      default:    rdata = '0;
    endcase
  end

  // R6
  cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_active && !wr_cfg |=> $stable(cfg_q));
  // R6
  ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_active && !wr_ctrl |=> $stable(ctrl_q));
endmodule

// File: rtl/phy_rst_strap_ctrl.sv
module phy_rst_strap_ctrl #(
  parameter int          STRAP_W      = 5,
  parameter int          SWRST_CYCLES = 16,
  parameter int          SYNC_STAGES  = 2,
  parameter logic [15:0] CFG_DEFAULT  = 16'h00A5
) (
  input  logic               clk,
  input  logic               hw_rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               mgmt_we,
  input  logic [4:0]         mgmt_addr,
  input  logic [15:0]        mgmt_wdata,
  output logic [15:0]        mgmt_rdata,
  output logic               dp_rst_o,
  output logic               buf_rst_o,
  output logic               strap_oe_o
);
  logic               rst_sync_n;
  logic [STRAP_W-1:0] strap_q;
  logic               strap_apply;
  logic               hw_done;
  logic               swrst_req;
  logic               swrst_active;

  phy_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(hw_rst_n), .rst_n_o(rst_sync_n));

  phy_strap_latch #(.STRAP_W(STRAP_W)) u_strap (
    .clk(clk), .rst_sync_n(rst_sync_n), .strap_i(strap_i),
    .strap_q(strap_q), .strap_apply(strap_apply), .hw_done(hw_done));

  phy_mgmt_regs #(.STRAP_W(STRAP_W), .CFG_DEFAULT(CFG_DEFAULT)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .hw_done(hw_done),
    .strap_apply(strap_apply), .strap_q(strap_q),
    .we(mgmt_we), .addr(mgmt_addr), .wdata(mgmt_wdata),
    .swrst_active(swrst_active), .swrst_req(swrst_req), .rdata(mgmt_rdata));

  phy_swrst_seq #(.LEN(SWRST_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .start_req(swrst_req),
    .active_o(swrst_active));

  assign dp_rst_o   = !hw_done || swrst_active;
  assign buf_rst_o  = !hw_done;
  assign strap_oe_o = hw_done;

  // R7
  swrst_scope_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    swrst_active |-> !buf_rst_o && strap_oe_o && dp_rst_o);
  // R1
  hw_outputs_chk: assert property (@(posedge clk)
    !rst_sync_n |-> dp_rst_o && buf_rst_o && !strap_oe_o);
endmodule

// File: tb/sim_phy_rst_strap_ctrl.sv
module sim_phy_rst_strap_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SW_LEN = 16;

  logic clk = 1'b0;
  logic hw_rst_n = 1'b0;
  logic [4:0] strap_i = '0;
  logic mgmt_we = 1'b0;
  logic [4:0] mgmt_addr = '0;
  logic [15:0] mgmt_wdata = '0;
  logic [15:0] mgmt_rdata;
  logic dp_rst_o, buf_rst_o, strap_oe_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_rst_strap_ctrl u0 (
    .clk(clk), .hw_rst_n(hw_rst_n), .strap_i(strap_i), .mgmt_we(mgmt_we),
    .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata),
    .dp_rst_o(dp_rst_o), .buf_rst_o(buf_rst_o), .strap_oe_o(strap_oe_o));

  function automatic logic [15:0] exp_ctrl(input logic [4:0] s);
    return (16'(s[0]) << 13) | (16'(s[1]) << 12) | (16'(s[2]) << 8);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    mgmt_addr = a;
    #1;
    v = mgmt_rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    mgmt_we = 1'b1; mgmt_addr = a; mgmt_wdata = d;
    @(posedge clk);
    @(negedge clk);
    mgmt_we = 1'b0;
  endtask

  // Hardware reset with strap value s; the pins change to late right after capture.
  task automatic t_hw_reset(input logic [4:0] s, input logic [4:0] late);
    logic [15:0] v;
    @(negedge clk);
    hw_rst_n = 1'b0;
    strap_i = s;
    #1;
    chk("R1 async assert", {13'd0, dp_rst_o, buf_rst_o, strap_oe_o}, 16'b110);
    @(negedge clk);
    hw_rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after edge1", {13'd0, dp_rst_o, buf_rst_o, strap_oe_o}, 16'b110);
    @(negedge clk);
    chk("R1 after edge2", {13'd0, dp_rst_o, buf_rst_o, strap_oe_o}, 16'b110);
    strap_i = late;
    @(negedge clk);
    chk("R1 after edge3", {13'd0, dp_rst_o, buf_rst_o, strap_oe_o}, 16'b001);
    rd(5'd1, v); chk("R2 strap readback", v, {11'd0, s});
    rd(5'd0, v); chk("R3 ctrl default", v, exp_ctrl(s));
    rd(5'd2, v); chk("R3 cfg default", v, 16'h00A5);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr(5'd0, 16'h4A00);
    rd(5'd0, v); chk("R4 ctrl write", v, 16'h4A00);
    wr(5'd2, 16'h1234);
    rd(5'd2, v); chk("R4 cfg write", v, 16'h1234);
    wr(5'd1, 16'hFFFF);
    rd(5'd1, v); chk("R4 strap read-only", v, 16'h0015);
    wr(5'd7, 16'hBEEF);
    rd(5'd7, v); chk("R4 unmapped", v, 16'h0000);
  endtask

  task automatic t_swrst();
    logic [15:0] v;
    wr(5'd0, 16'hCA00);
    for (int i = 0; i < SW_LEN; i++) begin
      chk("R5 dp_rst held", {15'd0, dp_rst_o}, 16'd1);
      chk("R7 buf/oe during swrst", {14'd0, buf_rst_o, strap_oe_o}, 16'b01);
      rd(5'd0, v); chk("R5 bit15 busy", {15'd0, v[15]}, 16'd1);
      if (i == 5) strap_i = 5'b01010;
      @(negedge clk);
    end
    chk("R5 dp_rst released", {15'd0, dp_rst_o}, 16'd0);
    rd(5'd0, v); chk("R6 ctrl kept", v, 16'h4A00);
    rd(5'd2, v); chk("R6 cfg kept", v, 16'h1234);
    rd(5'd1, v); chk("R6 no strap resample", v, 16'h0015);
  endtask

  task automatic t_ignore();
    wr(5'd0, 16'h8000);
    repeat (5) @(negedge clk);
    wr(5'd0, 16'h8000);
    for (int n = 7; n <= SW_LEN; n++) begin
      chk("R8 still running", {15'd0, dp_rst_o}, 16'd1);
      @(negedge clk);
    end
    chk("R8 no extension", {15'd0, dp_rst_o}, 16'd0);
  endtask

  task automatic t_abort();
    logic [15:0] v;
    wr(5'd2, 16'h5555);
    wr(5'd0, 16'h8000);
    repeat (4) @(negedge clk);
    t_hw_reset(5'b01010, 5'b11111);
    rd(5'd0, v); chk("R9 bit15 clear + defaults", v, exp_ctrl(5'b01010));
    rd(5'd2, v); chk("R9 cfg default", v, 16'h00A5);
    chk("R9 dp_rst released", {15'd0, dp_rst_o}, 16'd0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_hw_reset(5'b10101, 5'b00000);
    t_regs();
    t_swrst();
    t_ignore();
    t_abort();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule